// File: doc/BRIEF.md
# UART Control and Status Register Block

This block is the software-visible face of a simple 16450-class serial port. It sits on a 32-bit, word-addressed bus and holds eight registers: the data port, interrupt enables, interrupt identification, line control, modem control, line status, modem status and the baud divisor. The serial shifter and the baud generator live elsewhere. The block receives a one-cycle strobe with each byte the deserializer collects, and it issues a one-cycle strobe with each byte that software writes for transmission. It presents the stored line-control, modem-control and divisor values to those neighbours.

The receive side holds a single byte. A second byte that arrives before software reads the first still replaces the stored byte, and it marks an overrun. A four-level priority encoder looks at line errors, received data, an empty transmit holder and modem-status deltas. From these it drives one level interrupt line and a three-bit identification code. The code is combinational on the register state, so it reflects the state after every access and every arriving byte. A `rx_ready` output lets the deserializer hold off while a byte is still unread.

Top module: `uart_csr_block`

## Requirements
- R1: After reset the line status register reads 0x60 (bit5 transmit holding empty, bit6 transmitter empty, all other bits 0). Every other register is zero, `irq` is low, `irq_id` is 3'b001 and `rx_ready` is high.
- R2: The register word offsets are: data 0x00, interrupt enable 0x04, identification 0x08, line control 0x0C, modem control 0x10, line status 0x14, modem status 0x18, divisor 0x1C. Interrupt enable (bits [3:0]), line control (bits [7:0]), modem control (bits [1:0]) and divisor (bits [DIV_W-1:0]) take written data and drive `line_ctrl`, `modem_ctrl` and `divisor` from the next cycle. Reads of these four registers return zero.
- R3: Writes to the identification, line status and modem status registers change no state.
- R4: A `rx_strobe` stores `rx_byte` and sets data-ready (line status bit0), which drives `rx_ready` low. A read of offset 0x00 returns the stored byte in bits [7:0] and clears data-ready. If the read and a strobe fall in the same cycle, the read returns the old byte, the new byte is kept, data-ready stays set, and no overrun is recorded.
- R5: A strobe that arrives while data-ready is set, and with no data read in the same cycle, sets overrun (line status bit1). The new byte still replaces the stored one.
- R6: `rx_perr`, `rx_ferr` and `rx_brk`, when sampled with `rx_strobe`, set line status bits 2, 3 and 4. A read of the line status register returns the bits as they stood before the read and clears bits 1 to 4. Errors that arrive in the same cycle as that read are kept.
- R7: A full-word write to offset 0x00 pulses `tx_strobe` for one cycle, starting the next cycle, with `tx_byte` equal to write data bits [7:0].
- R8: The identification code follows a fixed priority, highest first: 3'b110 when any of line status bits 1..4 is set and enable bit2 is set; 3'b100 when data-ready and enable bit0 are set; 3'b010 when transmit-holding-empty and enable bit1 are set; 3'b000 when any of modem status bits 3..0 is set and enable bit3 is set. Reading offset 0x08 returns that code in bits [2:0].
- R9: When no condition of R8 holds, `irq_id` is 3'b001 and `irq` is low. Otherwise `irq` is high.
- R10: An access is rejected when its address is above 0x1C, is not a multiple of four, or has a byte strobe other than 4'hF. A rejected access changes no register, returns zero and pulses `rsp_err` for one cycle alongside `rsp_valid`.
- R11: Every request gives `rsp_valid` exactly one cycle later. On a read, `rsp_rdata` carries the register value as it stood in the request cycle.
- R12: The modem status register captures `modem_in` on every clock edge. Offset 0x18 returns it in bits [7:0], and its bits [3:0] feed the modem interrupt of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wstrb | input | 4 | Byte strobes; only 4'hF is accepted |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_rdata | output | 32 | Read data (zero for writes and rejected accesses) |
| rsp_err | output | 1 | Last cycle's request was rejected |
| rx_strobe | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error on this byte |
| rx_ferr | input | 1 | Framing error on this byte |
| rx_brk | input | 1 | Break seen with this byte |
| rx_ready | output | 1 | High while no unread byte is held |
| tx_strobe | output | 1 | One-cycle pulse with a byte to send |
| tx_byte | output | 8 | Byte to send |
| modem_in | input | 8 | Modem status inputs, deltas in [3:0] |
| line_ctrl | output | 8 | Stored line control value |
| modem_ctrl | output | 2 | Stored modem control value |
| divisor | output | DIV_W | Stored baud divisor |
| irq | output | 1 | Level interrupt request |
| irq_id | output | 3 | Prioritized interrupt identification code |

## Verification
All results are due one clock edge after the request or strobe that causes them. This covers the response, read data, error flag, transmit pulse, control outputs and stored receive state. `irq`, `irq_id` and `rx_ready` are combinational on that stored state, so they settle in the same cycle. The bench drives each stimulus on a falling edge, advances its reference model once at the following rising edge, and compares every output at the next falling edge. Read data is predicted from the model state before the update, which is the state in the request cycle. Directed steps cover overrun, the read-and-receive collision, clear-on-read of the error flags, each priority level and the rejected accesses. Seeded random traffic then mixes these cases.

// File: rtl/ucsr_pkg.sv
package ucsr_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int IEN_W   = 4;
    localparam int MCTL_W  = 2;
    localparam int IDX_W   = 3;
    localparam int IDX_LSB = 2;
    localparam int MAP_TOP = IDX_LSB + IDX_W;   // first address bit beyond the map
    localparam int IID_W   = 3;

    // word index of each register; order is the bus map
    typedef enum logic [IDX_W-1:0] {
        RIDX_DATA  = 3'd0,
        RIDX_IEN   = 3'd1,
        RIDX_IID   = 3'd2,
        RIDX_LCTL  = 3'd3,
        RIDX_MCTL  = 3'd4,
        RIDX_LSTAT = 3'd5,
        RIDX_MSTAT = 3'd6,
        RIDX_DIV   = 3'd7
    } reg_idx_e;

    // interrupt enable bit positions
    localparam int IEN_RXD  = 0;
    localparam int IEN_THR  = 1;
    localparam int IEN_LINE = 2;
    localparam int IEN_MDM  = 3;

    typedef enum logic [IID_W-1:0] {
        IID_LINE = 3'b110,
        IID_RXD  = 3'b100,
        IID_THR  = 3'b010,
        IID_MDM  = 3'b000,
        IID_NONE = 3'b001
    } iid_e;

    // line status, bit0 first from the right
    typedef struct packed {
        logic temt;
        logic thre;
        logic brk;
        logic ferr;
        logic perr;
        logic ovr;
        logic dr;
    } lstat_t;

    localparam lstat_t LSTAT_RST = '{temt: 1'b1, thre: 1'b1, default: 1'b0};

    function automatic logic lstat_has_err(input lstat_t ls);
        return ls.ovr | ls.perr | ls.ferr | ls.brk;
    endfunction

endpackage

// File: rtl/ucsr_bus_decode.sv
module ucsr_bus_decode
    import ucsr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_wstrb,
    output logic              acc_rd,
    output logic              acc_wr,
    output logic              acc_bad,
    output reg_idx_e          acc_idx
);
    logic in_map;

    always_comb begin
        in_map  = (req_addr[ADDR_W-1:MAP_TOP] == '0)
               && (req_addr[IDX_LSB-1:0] == '0)
               && (req_wstrb == 4'hF);
        acc_idx = reg_idx_e'(req_addr[MAP_TOP-1:IDX_LSB]);
        acc_rd  = req_valid && !req_write && in_map;
        acc_wr  = req_valid &&  req_write && in_map;
        acc_bad = req_valid && !in_map;
    end
endmodule

// File: rtl/ucsr_rx_hold.sv
module ucsr_rx_hold
    import ucsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_strobe,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              data_rd,
    input  logic              lstat_rd,
    output logic [BYTE_W-1:0] data_q,
    output lstat_t            lstat_q
);
    lstat_t lstat_d;

    always_comb begin
        lstat_d      = lstat_q;
        // a same-cycle data read consumes the old byte first
        lstat_d.dr   = rx_strobe | (lstat_q.dr & ~data_rd);
        lstat_d.ovr  = (lstat_q.ovr  & ~lstat_rd) | (rx_strobe & lstat_q.dr & ~data_rd);
        lstat_d.perr = (lstat_q.perr & ~lstat_rd) | (rx_strobe & rx_perr);
        lstat_d.ferr = (lstat_q.ferr & ~lstat_rd) | (rx_strobe & rx_ferr);
        lstat_d.brk  = (lstat_q.brk  & ~lstat_rd) | (rx_strobe & rx_brk);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            lstat_q <= LSTAT_RST;
        end else begin
            if (rx_strobe) begin
                data_q <= rx_byte;
            end
            lstat_q <= lstat_d;
        end
    end
endmodule

// File: rtl/ucsr_irq_prio.sv
module ucsr_irq_prio
    import ucsr_pkg::*;
(
    input  logic [IEN_W-1:0] ien,
    input  lstat_t           lstat,
    input  logic [3:0]       mdm_delta,
    output logic             irq,
    output iid_e             iid
);
    always_comb begin
        if (lstat_has_err(lstat) && ien[IEN_LINE]) begin
            iid = IID_LINE;
        end else if (lstat.dr && ien[IEN_RXD]) begin
            iid = IID_RXD;
        end else if (lstat.thre && ien[IEN_THR]) begin
            iid = IID_THR;
        end else if ((|mdm_delta) && ien[IEN_MDM]) begin
            iid = IID_MDM;
        end else begin
            iid = IID_NONE;
        end
        irq = (iid != IID_NONE);
    end
endmodule

// File: rtl/uart_csr_block.sv
module uart_csr_block
    import ucsr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_wstrb,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic              rx_strobe,
    input  logic [7:0]        rx_byte,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    output logic              rx_ready,
    output logic              tx_strobe,
    output logic [7:0]        tx_byte,
    input  logic [7:0]        modem_in,
    output logic [7:0]        line_ctrl,
    output logic [1:0]        modem_ctrl,
    output logic [DIV_W-1:0]  divisor,
    output logic              irq,
    output logic [2:0]        irq_id
);
    logic              acc_rd, acc_wr, acc_bad;
    reg_idx_e          acc_idx;
    logic              data_rd, lstat_rd;
    logic [BYTE_W-1:0] data_q;
    lstat_t            lstat_q;
    logic [IEN_W-1:0]  ien_q;
    logic [7:0]        lctl_q;
    logic [MCTL_W-1:0] mctl_q;
    logic [DIV_W-1:0]  div_q;
    logic [7:0]        mstat_q;
    iid_e              iid;
    logic              irq_w;
    logic [WORD_W-1:0] rd_mux;
    logic              unused_wdata;

    assign unused_wdata = ^req_wdata;

    ucsr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wstrb (req_wstrb),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .acc_bad   (acc_bad),
        .acc_idx   (acc_idx)
    );

    assign data_rd  = acc_rd && (acc_idx == RIDX_DATA);
    assign lstat_rd = acc_rd && (acc_idx == RIDX_LSTAT);

    ucsr_rx_hold u_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_strobe (rx_strobe),
        .rx_byte   (rx_byte),
        .rx_perr   (rx_perr),
        .rx_ferr   (rx_ferr),
        .rx_brk    (rx_brk),
        .data_rd   (data_rd),
        .lstat_rd  (lstat_rd),
        .data_q    (data_q),
        .lstat_q   (lstat_q)
    );

    ucsr_irq_prio u_prio (
        .ien       (ien_q),
        .lstat     (lstat_q),
        .mdm_delta (mstat_q[3:0]),
        .irq       (irq_w),
        .iid       (iid)
    );

    // writable control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= '0;
            lctl_q <= '0;
            mctl_q <= '0;
            div_q  <= '0;
        end else if (acc_wr) begin
            unique case (acc_idx)
                RIDX_IEN:  ien_q  <= req_wdata[IEN_W-1:0];
                RIDX_LCTL: lctl_q <= req_wdata[7:0];
                RIDX_MCTL: mctl_q <= req_wdata[MCTL_W-1:0];
                RIDX_DIV:  div_q  <= req_wdata[DIV_W-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mstat_q <= '0;
        end else begin
            mstat_q <= modem_in;
        end
    end

    // read data; write-only registers return zero
    always_comb begin
        rd_mux = '0;
        unique case (acc_idx)
            RIDX_DATA:  rd_mux[BYTE_W-1:0] = data_q;
            RIDX_IID:   rd_mux[IID_W-1:0]  = iid;
            RIDX_LSTAT: rd_mux[6:0]        = lstat_q;
            RIDX_MSTAT: rd_mux[7:0]        = mstat_q;
            default:    rd_mux             = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            tx_strobe <= 1'b0;
            tx_byte   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= acc_bad;
            rsp_rdata <= acc_rd ? rd_mux : '0;
            tx_strobe <= acc_wr && (acc_idx == RIDX_DATA);
            if (acc_wr && (acc_idx == RIDX_DATA)) begin
                tx_byte <= req_wdata[7:0];
            end
        end
    end

    assign rx_ready   = ~lstat_q.dr;
    assign line_ctrl  = lctl_q;
    assign modem_ctrl = mctl_q;
    assign divisor    = div_q;
    assign irq        = irq_w;
    assign irq_id     = iid;
endmodule

// File: rtl/ucsr_checker.sv
module ucsr_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_wstrb,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              rx_strobe,
    input logic              rx_ready,
    input logic              tx_strobe,
    input logic [7:0]        tx_byte,
    input logic              irq,
    input logic [2:0]        irq_id,
    input logic [6:0]        lstat_bits
);
    logic bad, good, rd_data, rd_lstat, wr_data;

    always_comb begin
        bad      = req_valid && ((req_addr[ADDR_W-1:5] != '0) || (req_addr[1:0] != 2'b00)
                                 || (req_wstrb != 4'hF));
        good     = req_valid && !bad;
        rd_data  = good && !req_write && (req_addr[4:2] == 3'd0);
        rd_lstat = good && !req_write && (req_addr[4:2] == 3'd5);
        wr_data  = good &&  req_write && (req_addr[4:2] == 3'd0);
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rx_ready && !irq && lstat_bits == 7'h60));

    p_rx_sets_ready_r4: assert property (@(posedge clk) disable iff (rst)
        rx_strobe |=> !rx_ready);

    p_overrun_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_strobe && !rx_ready && !rd_data) |=> lstat_bits[1]);

    p_lstat_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_lstat && !rx_strobe) |=> (lstat_bits[4:1] == 4'b0000));

    p_tx_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> (tx_strobe && tx_byte == $past(req_wdata[7:0])));

    p_no_tx_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_data |=> !tx_strobe);

    p_idle_code_r9: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (irq_id == 3'b001));

    p_reject_flag_r10: assert property (@(posedge clk) disable iff (rst)
        bad |=> (rsp_err && rsp_valid));

    p_response_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_no_response_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_err));
endmodule

bind uart_csr_block ucsr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wstrb  (req_wstrb),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rx_strobe  (rx_strobe),
    .rx_ready   (rx_ready),
    .tx_strobe  (tx_strobe),
    .tx_byte    (tx_byte),
    .irq        (irq),
    .irq_id     (irq_id),
    .lstat_bits (lstat_q)
);

// File: tb/sim_uart_csr_block.sv
module sim_uart_csr_block;
    localparam int ADDR_W = 8;
    localparam int DIV_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        req_wstrb = 4'hF;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid, rsp_err;
    logic [31:0]       rsp_rdata;
    logic              rx_strobe = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
    logic [7:0]        rx_byte = '0;
    logic              rx_ready, tx_strobe;
    logic [7:0]        tx_byte;
    logic [7:0]        modem_in = '0;
    logic [7:0]        line_ctrl;
    logic [1:0]        modem_ctrl;
    logic [DIV_W-1:0]  divisor;
    logic              irq;
    logic [2:0]        irq_id;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [7:0]  m_data = '0;
    logic        m_dr = 0, m_oe = 0, m_pe = 0, m_fe = 0, m_bi = 0;
    logic [3:0]  m_ier = '0;
    logic [7:0]  m_lcr = '0;
    logic [1:0]  m_mcr = '0;
    logic [15:0] m_div = '0;
    logic [7:0]  m_msr = '0;

    always #10 clk = ~clk;

    uart_csr_block #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wstrb(req_wstrb), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .rx_strobe(rx_strobe), .rx_byte(rx_byte), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_ready(rx_ready),
        .tx_strobe(tx_strobe), .tx_byte(tx_byte), .modem_in(modem_in),
        .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl), .divisor(divisor),
        .irq(irq), .irq_id(irq_id)
    );

    function automatic logic [6:0] m_lsr();
        return {1'b1, 1'b1, m_bi, m_fe, m_pe, m_oe, m_dr};
    endfunction

    function automatic logic [2:0] m_id();
        if ((m_oe | m_pe | m_fe | m_bi) && m_ier[2]) return 3'b110;
        if (m_dr && m_ier[0])                        return 3'b100;
        if (m_ier[1])                                return 3'b010;
        if ((m_msr[3:0] != 0) && m_ier[3])           return 3'b000;
        return 3'b001;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // one bus/receive cycle: drive at negedge, check at the next negedge
    task automatic step(input logic v, input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic [3:0] s, input logic rs, input logic [7:0] rb,
                        input logic pe, input logic fe, input logic bi, input logic [7:0] mi);
        logic bad, rd, wr, drd, lrd, txe;
        logic [2:0] idx;
        logic [31:0] exp_rd;
        string rtag;
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_wstrb = s;
        rx_strobe = rs; rx_byte = rb; rx_perr = pe; rx_ferr = fe; rx_brk = bi; modem_in = mi;
        bad = v && ((a[7:5] != 0) || (a[1:0] != 0) || (s != 4'hF));
        idx = a[4:2];
        rd  = v && !w && !bad;
        wr  = v &&  w && !bad;
        drd = rd && idx == 3'd0;
        lrd = rd && idx == 3'd5;
        txe = wr && idx == 3'd0;
        case (idx)
            3'd0:    begin exp_rd = {24'b0, m_data};    rtag = "R4";  end
            3'd2:    begin exp_rd = {29'b0, m_id()};    rtag = "R8";  end
            3'd5:    begin exp_rd = {25'b0, m_lsr()};   rtag = "R6";  end
            3'd6:    begin exp_rd = {24'b0, m_msr};     rtag = "R12"; end
            default: begin exp_rd = 32'b0;              rtag = "R2";  end
        endcase
        if (bad) begin exp_rd = 32'b0; rtag = "R10"; end
        // model update (R3: writes to 2, 5, 6 have no case here)
        if (wr) begin
            case (idx)
                3'd1: m_ier = d[3:0];
                3'd3: m_lcr = d[7:0];
                3'd4: m_mcr = d[1:0];
                3'd7: m_div = d[15:0];
                default: ;
            endcase
        end
        m_oe = (m_oe & ~lrd) | (rs & m_dr & ~drd);
        m_pe = (m_pe & ~lrd) | (rs & pe);
        m_fe = (m_fe & ~lrd) | (rs & fe);
        m_bi = (m_bi & ~lrd) | (rs & bi);
        m_dr = rs | (m_dr & ~drd);
        if (rs) m_data = rb;
        m_msr = mi;
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == v, "R11", rsp_valid, v);
        chk(rsp_err == bad, "R10", rsp_err, bad);
        if (v && !w) chk(rsp_rdata == exp_rd, rtag, rsp_rdata, exp_rd);
        chk(tx_strobe == txe, "R7", tx_strobe, txe);
        if (txe) chk(tx_byte == d[7:0], "R7", tx_byte, d[7:0]);
        chk(irq_id == m_id(), "R8", irq_id, m_id());
        chk(irq == (m_id() != 3'b001), "R9", irq, m_id() != 3'b001);
        chk(rx_ready == !m_dr, "R4", rx_ready, !m_dr);
        chk(line_ctrl == m_lcr, "R2", line_ctrl, m_lcr);
        chk(modem_ctrl == m_mcr, "R2", modem_ctrl, m_mcr);
        chk(divisor == m_div, "R2", divisor, m_div);
    endtask

    task automatic rd(input logic [7:0] a);
        step(1, 0, a, 0, 4'hF, 0, 0, 0, 0, 0, m_msr);
    endtask
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1, 1, a, d, 4'hF, 0, 0, 0, 0, 0, m_msr);
    endtask
    task automatic rx(input logic [7:0] b, input logic pe, input logic fe, input logic bi);
        step(0, 0, 0, 0, 4'hF, 1, b, pe, fe, bi, m_msr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        report();
    end

    initial begin
        void'($urandom(32'h5eed_2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(rx_ready == 1'b1, "R1", rx_ready, 1);
        chk(irq == 1'b0, "R1", irq, 0);
        chk(irq_id == 3'b001, "R1", irq_id, 3'b001);
        rd(8'h14);                    // R1 line status 0x60
        rd(8'h08);                    // R9 idle code
        // R2: write-only registers
        wr(8'h0C, 32'hFFFF_FFA5); rd(8'h0C);
        wr(8'h10, 32'h0000_0003); rd(8'h10);
        wr(8'h1C, 32'h1234_BEEF); rd(8'h1C);
        // R3: read-only registers ignore writes
        wr(8'h14, 32'hFFFF_FFFF); rd(8'h14);
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08);
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18);
        // R4/R5: receive, overrun, read
        rx(8'h3C, 0, 0, 0);
        rx(8'h5A, 0, 0, 0);
        rd(8'h00); rd(8'h14); rd(8'h14);
        // R4: read and receive in the same cycle
        rx(8'h11, 0, 0, 0);
        step(1, 0, 8'h00, 0, 4'hF, 1, 8'h22, 0, 0, 0, 0);
        rd(8'h14); rd(8'h00);
        // R6: error flags, clear on read, collision with read
        rx(8'h01, 1, 0, 0); rx(8'h02, 0, 1, 1);
        step(1, 0, 8'h14, 0, 4'hF, 1, 8'h03, 1, 0, 0, 0);
        rd(8'h14); rd(8'h14); rd(8'h00);
        // R8: each priority level
        wr(8'h04, 32'h8); step(0, 0, 0, 0, 4'hF, 0, 0, 0, 0, 0, 8'h01); rd(8'h08);
        wr(8'h04, 32'hA); rd(8'h08);
        wr(8'h04, 32'h9); rx(8'h44, 0, 0, 0); rd(8'h08);
        wr(8'h04, 32'hF); rx(8'h45, 0, 1, 0); rd(8'h08);
        rd(8'h14); rd(8'h08); rd(8'h00); rd(8'h08);
        step(0, 0, 0, 0, 4'hF, 0, 0, 0, 0, 0, 8'hF0);
        wr(8'h04, 32'h0); rd(8'h08);
        // R7: transmit
        wr(8'h00, 32'hDEAD_BE77); wr(8'h00, 32'h0000_0100);
        // R10: rejected accesses
        wr(8'h20, 32'hF); rd(8'h24); wr(8'h05, 32'hF);
        step(1, 1, 8'h04, 32'hF, 4'h3, 0, 0, 0, 0, 0, 0);
        step(1, 1, 8'h00, 32'h55, 4'h1, 0, 0, 0, 0, 0, 0);
        rd(8'h04); rd(8'hFC);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a;
            logic [3:0] s;
            logic [7:0] mi;
            int r;
            r = $urandom % 16;
            s = 4'hF;
            if (r < 13)       a = {3'b000, 3'($urandom), 2'b00};
            else if (r == 13) a = 8'($urandom) | 8'h20;
            else if (r == 14) a = {3'b000, 3'($urandom), 2'($urandom % 3 + 1)};
            else begin        a = {3'b000, 3'($urandom), 2'b00}; s = 4'($urandom); end
            mi = (($urandom % 16) == 0) ? 8'($urandom) : m_msr;
            step(($urandom % 3) != 0, $urandom % 2, a, $urandom, s,
                 ($urandom % 4) == 0, 8'($urandom),
                 ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0, mi);
        end
        step(0, 0, 0, 0, 4'hF, 0, 0, 0, 0, 0, m_msr);
        report();
    end
endmodule